// File: doc/BRIEF.md
# Serial Boot-Mode Bit Loader

This block brings a processor's 256 boot configuration bits in from an external serial memory while the chip sits in power-on or cold reset. It runs from the master clock. It makes a slow mode clock for the serial memory at one 256th of the master clock rate. On each rising edge of that mode clock it takes one bit from the serial data pin. The bits land in a 256-bit register in arrival order. The first bit received is stored at index 0.

A load begins once the power-good input and the cold-reset input are both high. The mode clock rests high until then. Its first rising edge comes 256 master-clock cycles after the start condition is first seen. After the 256th bit the done flag rises. The mode clock keeps running until cold reset is raised again. A fresh rising edge of cold reset stops the loader and clears its contents, and the loader then waits for power-good to drop and return. Indices 65 and above are reserved and must arrive as zero. A one in any of them sets a sticky error flag.

The mode bits, the done flag and the error flag are plain level outputs. The serial input is sampled on a fixed schedule, so there is no valid/ready pair and no back-pressure: the source must present each bit before the matching mode-clock rise.

Top module: `boot_mode_loader`

## Requirements
- R1: While loading or after done, `mode_clk_o` has a period of 256 master-clock cycles: high for 128 cycles, then low for 128 cycles.
- R2: `mode_clk_o` is high whenever the loader is idle. This covers power-good low, no start yet, and the halted state after a cold-reset rise.
- R3: Loading starts only when `pwr_ok_i` and `cold_rst_i` are both high. If the start condition is first seen at edge E0, the first mode-clock rise is at edge E0+256. With `cold_rst_i` low, no start occurs.
- R4: The k-th mode-clock rise (k counting from 1) stores the `mode_in_i` value present at that master-clock edge into `mode_bits_o[k-1]`.
- R5: `load_done_o` rises at the edge of the 256th capture and stays high. Later mode-clock rises change no bit of `mode_bits_o`.
- R6: `rsv_err_o` is set at the edge of any capture at index 65 or above whose value is 1, and it stays set. Ones at indices 0 to 64 never set it.
- R7: After done, `mode_clk_o` keeps toggling while `cold_rst_i` stays low or stays high.
- R8: A rising edge of `cold_rst_i` during a load, or after done, clears `mode_bits_o`, `load_done_o` and `rsv_err_o` at that edge. It returns `mode_clk_o` high, and no new load starts until `pwr_ok_i` has been low.
- R9: `pwr_ok_i` low at a master-clock edge clears the bits, done and error at that edge and returns the loader to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| master_clk_i | input | 1 | Master clock |
| pwr_ok_i | input | 1 | Power good; low holds the loader idle and cleared |
| cold_rst_i | input | 1 | Cold reset request; high with power good starts a load, a new rise halts it |
| mode_in_i | input | 1 | Serial mode data from the boot memory |
| mode_clk_o | output | 1 | Generated mode clock, master clock / 256 |
| mode_bits_o | output | 256 | Loaded mode bits, index 0 received first |
| load_done_o | output | 1 | All 256 bits captured |
| rsv_err_o | output | 1 | A reserved bit (index 65 or above) arrived as 1 |

## Verification
The bench aims at the start delay. A divider that begins low, or that counts one cycle short or long, moves the first rise off edge 256 and shifts every capture. It then checks the reserved boundary with ones at indices 64 and 65, and with a lone one at index 255. An off-by-one compare flags index 64 or misses the last bit. It drives ones on the data pin after done to catch a loader that keeps writing. It also holds both start inputs high after a cold-reset halt: a design that re-arms on the level instead of waiting for power-good would start a second load.

// File: rtl/bml_pkg.sv
package bml_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HALT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bml_clock_div.sv
module bml_clock_div #(
  parameter int DIV_RATIO = 256
) (
  input  logic clk,
  input  logic pwr_ok_i,
  input  logic run_i,
  output logic mode_clk_o,
  output logic cap_stb_o
);
  localparam int CW   = $clog2(DIV_RATIO);
  localparam int HALF = DIV_RATIO / 2;
  localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] HALF_V = CW'(HALF);

  logic [CW-1:0] phase_q;

  // Phase counter: held at zero while idle, so the mode clock rests high.
  always_ff @(posedge clk) begin
    if (!run_i)               phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  // High during the first half of each period; the wrap to zero is the rise.
  assign mode_clk_o = (phase_q < HALF_V);
  assign cap_stb_o  = run_i && (phase_q == LAST);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    !run_i |=> mode_clk_o);
  assert_capture_on_rise_R4: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    cap_stb_o |=> $rose(mode_clk_o));
  assert_half_low_R1: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    (run_i && $fell(mode_clk_o)) |=> (!mode_clk_o || !run_i));
endmodule

// File: rtl/bml_sequencer.sv
module bml_sequencer
  import bml_pkg::*;
#(
  parameter int NBITS = 256
) (
  input  logic                      clk,
  input  logic                      pwr_ok_i,
  input  logic                      cold_i,
  input  logic                      cap_stb_i,
  output logic                      run_o,
  output logic                      cap_en_o,
  output logic [$clog2(NBITS)-1:0]  idx_o,
  output logic                      done_o
);
  localparam int IDXW = $clog2(NBITS);
  localparam int CNTW = $clog2(NBITS + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(NBITS);

  seq_state_e      state_q;
  logic            cold_q;
  logic            halt_req;
  logic [CNTW-1:0] bit_cnt_q;

  assign halt_req = (state_q == SEQ_RUN) && cold_i && !cold_q;
  assign run_o    = pwr_ok_i && (state_q == SEQ_RUN) && !halt_req;
  assign done_o   = (bit_cnt_q == FULL);
  assign cap_en_o = run_o && cap_stb_i && !done_o;
  assign idx_o    = bit_cnt_q[IDXW-1:0];

  always_ff @(posedge clk) begin
    cold_q <= cold_i;
    if (!pwr_ok_i) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (cold_i)   state_q <= SEQ_RUN;
        SEQ_RUN:  if (halt_req) state_q <= SEQ_HALT;
        SEQ_HALT: state_q <= SEQ_HALT;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!run_o)        bit_cnt_q <= '0;
    else if (cap_en_o) bit_cnt_q <= bit_cnt_q + 1'b1;
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    bit_cnt_q <= FULL);
  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    (done_o && run_o && !cold_i) |=> done_o);
  assert_no_start_R3: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    (state_q == SEQ_IDLE && !cold_i) |=> !run_o);
  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    halt_req |=> (!run_o && !done_o));
endmodule

// File: rtl/bml_capture_reg.sv
module bml_capture_reg #(
  parameter int NBITS  = 256,
  parameter int RSV_LO = 65
) (
  input  logic                     clk,
  input  logic                     pwr_ok_i,
  input  logic                     clear_i,
  input  logic                     cap_en_i,
  input  logic [$clog2(NBITS)-1:0] idx_i,
  input  logic                     bit_i,
  output logic [NBITS-1:0]         bits_o,
  output logic                     err_o
);
  localparam int IDXW = $clog2(NBITS);
  localparam logic [IDXW-1:0] RSV_IDX = IDXW'(RSV_LO);

  logic [NBITS-1:0] bits_q;
  logic             err_q;
  logic             in_rsv;

  for (genvar g = 0; g < NBITS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (clear_i)                             bits_q[g] <= 1'b0;
      else if (cap_en_i && idx_i == IDXW'(g))  bits_q[g] <= bit_i;
    end
  end

  assign in_rsv = (idx_i >= RSV_IDX);

  always_ff @(posedge clk) begin
    if (clear_i)                          err_q <= 1'b0;
    else if (cap_en_i && in_rsv && bit_i) err_q <= 1'b1;
  end

  assign bits_o = bits_q;
  assign err_o  = err_q;

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    (err_q && !clear_i) |=> err_q);
  assert_low_bits_no_err_R6: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    (cap_en_i && !in_rsv && !err_q && !clear_i) |=> !err_q);
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    clear_i |=> (bits_q == '0 && !err_q));
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
  parameter int NBITS     = 256,
  parameter int RSV_LO    = 65,
  parameter int DIV_RATIO = 256
) (
  input  logic             master_clk_i,
  input  logic             pwr_ok_i,
  input  logic             cold_rst_i,
  input  logic             mode_in_i,
  output logic             mode_clk_o,
  output logic [NBITS-1:0] mode_bits_o,
  output logic             load_done_o,
  output logic             rsv_err_o
);
  localparam int IDXW = $clog2(NBITS);

  logic            run;
  logic            cap_stb;
  logic            cap_en;
  logic [IDXW-1:0] idx;

  bml_sequencer #(.NBITS(NBITS)) u_seq (
    .clk       (master_clk_i),
    .pwr_ok_i  (pwr_ok_i),
    .cold_i    (cold_rst_i),
    .cap_stb_i (cap_stb),
    .run_o     (run),
    .cap_en_o  (cap_en),
    .idx_o     (idx),
    .done_o    (load_done_o)
  );

  bml_clock_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk        (master_clk_i),
    .pwr_ok_i   (pwr_ok_i),
    .run_i      (run),
    .mode_clk_o (mode_clk_o),
    .cap_stb_o  (cap_stb)
  );

  bml_capture_reg #(.NBITS(NBITS), .RSV_LO(RSV_LO)) u_cap (
    .clk      (master_clk_i),
    .pwr_ok_i (pwr_ok_i),
    .clear_i  (!run),
    .cap_en_i (cap_en),
    .idx_i    (idx),
    .bit_i    (mode_in_i),
    .bits_o   (mode_bits_o),
    .err_o    (rsv_err_o)
  );

  assert_done_rises_on_capture_R5: assert property (@(posedge master_clk_i) disable iff (!pwr_ok_i)
    $rose(load_done_o) |-> $rose(mode_clk_o));
endmodule

// File: tb/boot_mode_loader_test.sv
module boot_mode_loader_test;
  logic         clk = 1'b0;
  logic         vcc = 1'b0;
  logic         cold = 1'b0;
  logic         mode_in = 1'b0;
  logic         mode_clk;
  logic [255:0] bits;
  logic         done;
  logic         err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  // reference model state
  int           m_state = 0;   // 0 idle, 1 loading, 2 halted
  int           m_k = 0;
  int           m_n = 0;
  logic [255:0] m_bits = '0;
  logic         m_err = 1'b0;
  logic         m_prev_cold = 1'b0;

  logic [255:0] cur_pat = '0;
  logic         tail_val = 1'b0;

  always #2.5 clk = ~clk;

  boot_mode_loader uut (
    .master_clk_i (clk),
    .pwr_ok_i     (vcc),
    .cold_rst_i   (cold),
    .mode_in_i    (mode_in),
    .mode_clk_o   (mode_clk),
    .mode_bits_o  (bits),
    .load_done_o  (done),
    .rsv_err_o    (err)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural model, evaluated from inputs held steady across the edge
  always @(posedge clk) begin
    if (!vcc) begin
      m_state = 0; m_k = 0; m_n = 0; m_bits = '0; m_err = 1'b0;
    end else if (m_state == 0) begin
      if (cold) begin m_state = 1; m_k = 0; end
    end else if (m_state == 1) begin
      if (cold && !m_prev_cold) begin
        m_state = 2; m_k = 0; m_n = 0; m_bits = '0; m_err = 1'b0;
      end else begin
        m_k = m_k + 1;
        if (m_k % 256 == 0 && m_n < 256) begin
          m_bits[m_n] = mode_in;
          if (m_n >= 65 && mode_in) m_err = 1'b1;
          m_n = m_n + 1;
        end
      end
    end
    m_prev_cold = cold;
  end

  always @(negedge clk) mode_in = (m_n < 256) ? cur_pat[m_n] : tail_val;

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      logic exp_clk;
      exp_clk = (m_state == 1) ? ((m_k % 256) < 128) : 1'b1;
      if (m_state == 1) chk("R1", 256'(mode_clk), 256'(exp_clk), "mode clock waveform");
      else              chk("R2", 256'(mode_clk), 256'(exp_clk), "idle mode clock level");
      chk("R4", bits, m_bits, "mode register contents");
      chk("R5", 256'(done), 256'((m_state == 1) && (m_n == 256)), "done flag");
      chk("R6", 256'(err), 256'(m_err), "reserved error flag");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [255:0] pat_a, pat_b, pat_c;
    int n;
    bit seen_low;
    int rises;
    logic last_clk;

    pat_a = '0; pat_b = '0; pat_c = '0;
    for (int k = 0; k < 65; k++) begin
      pat_a[k] = ((k * 7 + 3) % 5) < 2;
      pat_b[k] = ((k * 3 + 1) % 4) == 0;
      pat_c[k] = (k % 3) == 1;
    end
    pat_b[64] = 1'b1;
    pat_b[65] = 1'b1;
    pat_c[255] = 1'b1;

    repeat (5) @(negedge clk);
    cmp_on = 1'b1;
    #1;
    chk("R2", 256'(mode_clk), 256'(1'b1), "mode clock after reset");
    chk("R9", bits, '0, "bits after reset");
    chk("R9", 256'({done, err}), '0, "flags after reset");

    // power good without cold reset: nothing starts
    @(negedge clk); vcc = 1'b1;
    repeat (300) @(negedge clk);
    #1;
    chk("R3", 256'(mode_clk), 256'(1'b1), "no start with cold reset low");
    chk("R3", 256'(done), '0, "no done with cold reset low");

    // load 1
    cur_pat = pat_a; tail_val = 1'b1;
    @(negedge clk); cold = 1'b1;
    @(posedge clk);
    n = 0; seen_low = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (seen_low && mode_clk) break;
      if (!mode_clk) seen_low = 1'b1;
      n++;
    end
    chk("R3", 256'(n), 256'(256), "cycles from start to first rise");
    chk("R4", 256'(bits[0]), 256'(pat_a[0]), "first captured bit at index 0");

    wait (m_n == 256);
    @(negedge clk); #1;
    chk("R5", 256'(done), 256'(1'b1), "done after 256 captures");
    chk("R4", bits, pat_a, "full pattern A");
    chk("R6", 256'(err), '0, "no error with reserved bits zero");

    // keep running after done with ones on the data pin
    @(negedge clk); cold = 1'b0;
    rises = 0; last_clk = mode_clk;
    repeat (600) begin
      @(negedge clk); #1;
      if (mode_clk && !last_clk) rises++;
      last_clk = mode_clk;
    end
    chk("R7", 256'(rises >= 2), 256'(1'b1), "mode clock toggles after done");
    chk("R5", bits, pat_a, "no capture after done");

    // cold reset rise halts and clears
    @(negedge clk); cold = 1'b1;
    @(negedge clk); #1;
    chk("R8", bits, '0, "bits cleared by cold reset rise");
    chk("R8", 256'({done, err, mode_clk}), 256'(3'b001), "flags cleared and clock high");
    repeat (500) @(negedge clk);
    #1;
    chk("R8", 256'({done, mode_clk}), 256'(2'b01), "no restart until power drops");

    // load 2: reserved boundary
    cur_pat = pat_b;
    @(negedge clk); vcc = 1'b0;
    repeat (3) @(negedge clk);
    vcc = 1'b1;
    wait (m_n == 65);
    @(negedge clk); #1;
    chk("R6", 256'(err), '0, "one at index 64 leaves error clear");
    wait (m_n == 66);
    @(negedge clk); #1;
    chk("R6", 256'(err), 256'(1'b1), "one at index 65 sets error");
    repeat (700) @(negedge clk);
    #1;
    chk("R6", 256'(err), 256'(1'b1), "error stays set");
    @(negedge clk); vcc = 1'b0;
    @(negedge clk); #1;
    chk("R9", bits, '0, "power drop clears bits");
    chk("R9", 256'({done, err, mode_clk}), 256'(3'b001), "power drop clears flags");

    // load 3: only the last reserved bit set
    cur_pat = pat_c; tail_val = 1'b0;
    repeat (2) @(negedge clk);
    vcc = 1'b1;
    wait (m_n == 255);
    @(negedge clk); #1;
    chk("R6", 256'(err), '0, "no error before last capture");
    wait (m_n == 256);
    @(negedge clk); #1;
    chk("R6", 256'(err), 256'(1'b1), "one at index 255 sets error");
    chk("R4", bits, pat_c, "full pattern C");
    chk("R5", 256'(done), 256'(1'b1), "done on second full load");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule